// File: doc/BRIEF.md
# HDLC Frame Status FIFO

This block sits beside the receive path of a bit-oriented (SDLC/HDLC) serial channel. It counts the bytes that the deframer writes into the receive data FIFO. On every closing flag it stores that count, together with the frame's end status, as one entry in a ten-deep status queue. The receiver can then start the next frame while the host still reads the result of the earlier ones. The host reads two byte-wide views: the low count byte and a high byte. The high byte carries the top six count bits, a data-available bit and a sticky overflow bit. Reading the high view retires the head entry.

With the enable control clear, the block runs in emulation mode. Nothing is held, the queue is empty and the views show the live counter (held at zero) and the live receiver status. The deframer, the CRC logic and the receive data FIFO are outside the block.

Top module: `hdlc_frame_status_fifo`

## Requirements
- R1: While `hdlc_mode_i` and `fifo_en_i` are both 1, each cycle with `rx_wr_i` high adds one to the live byte count. While either of them is 0, the live count is held at 0.
- R2: A cycle with `flag_i` high while both controls are 1 stores an entry holding the count from before that edge and `eof_stat_i`. The live count then restarts at 1 if `rx_wr_i` is also high, else at 0.
- R3: The live count saturates at 16383. A write at 16383 leaves it there.
- R4: The queue holds 10 entries. A flag that arrives while 10 entries are held, and no pop happens in the same cycle, drops its entry and sets bit 7 of `cnt_hi_o` (`ovf_o`). That bit stays set until `fifo_en_i` goes low.
- R5: Bit 6 of `cnt_hi_o` (`avail_o`) is 1 exactly when the queue is not empty. While it is 1, `cnt_lo_o` shows head count bits 7:0, `cnt_hi_o[5:0]` shows head count bits 13:8 and `stat_o` shows the head status. While it is 0, the views show the live count and `eof_stat_i`.
- R6: `rd_hi_i` high while `avail_o` is 1 removes the head entry at that edge. `rd_lo_i` never removes an entry.
- R7: `fifo_en_i` low empties the queue and clears the overflow bit at the next edge.
- R8: Entries leave the queue in the order they were stored.
- R9: After reset the queue is empty, overflow is 0 and the live count is 0.
- R10: With `hdlc_mode_i` low and `fifo_en_i` high, flags store nothing and the entries already held are kept and can still be read out.
- R11: The status field is `{eof_mark, crc_err, residue[2:0]}` (bits 4, 3, 2:0). The block stores it unaltered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hdlc_mode_i | input | 1 | Channel is in SDLC/HDLC mode |
| fifo_en_i | input | 1 | Status queue enable control |
| rx_wr_i | input | 1 | Byte written to receive data FIFO |
| flag_i | input | 1 | Flag detected (frame end) pulse |
| eof_stat_i | input | 5 | Live receiver frame status |
| rd_lo_i | input | 1 | Host read of low count view |
| rd_hi_i | input | 1 | Host read of high count view (pops) |
| cnt_lo_o | output | 8 | Count bits 7:0 view |
| cnt_hi_o | output | 8 | {ovf, avail, count bits 13:8} view |
| stat_o | output | 5 | Status view (head or live) |
| ovf_o | output | 1 | Sticky overflow flag |
| avail_o | output | 1 | Queue holds at least one entry |

## Verification
A wrong occupancy or pointer shows up at the ports as a wrong `avail_o` or a wrong head entry. This appears on the first read after the push or pop where it went wrong, because every view is driven combinationally from the head. An error in the counter reaches the ports in the same cycle through the live view while the queue is empty, or one frame later as a stored count. A lost overflow bit shows on the first flag that arrives into a full queue. The bench keeps a model of the queue and of the counter and compares every port on every cycle, so a divergence is reported in the cycle it appears.

// File: rtl/hfs_pkg.sv
package hfs_pkg;
  localparam int unsigned CNT_W   = 14;
  localparam int unsigned STAT_W  = 5;
  localparam int unsigned DEPTH   = 10;
  localparam int unsigned ENTRY_W = CNT_W + STAT_W;

  typedef struct packed {
    logic             eof_mark;
    logic             crc_err;
    logic [2:0]       residue;
  } frame_stat_t;

  typedef struct packed {
    frame_stat_t      stat;
    logic [CNT_W-1:0] cnt;
  } stat_entry_t;
endpackage

// File: rtl/hfs_byte_counter.sv
module hfs_byte_counter #(
  parameter int unsigned CNT_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             inc_i,
  input  logic             restart_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!en_i)                       cnt_d = '0;
    else if (restart_i)              cnt_d = inc_i ? CNT_ONE : '0;
    else if (inc_i && cnt_q != CNT_MAX) cnt_d = cnt_q + CNT_ONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  AST_CNT_SATURATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && inc_i && !restart_i && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX)); // R3
  AST_CNT_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0)); // R1
  AST_CNT_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && restart_i && !inc_i) |=> (cnt_q == '0)); // R2
endmodule

// File: rtl/hfs_status_store.sv
module hfs_status_store #(
  parameter int unsigned DEPTH   = 10,
  parameter int unsigned ENTRY_W = 19
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               flush_i,
  input  logic               push_i,
  input  logic               pop_i,
  input  logic [ENTRY_W-1:0] din_i,
  output logic [ENTRY_W-1:0] head_o,
  output logic               avail_o,
  output logic               ovf_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned OCC_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [OCC_W-1:0] OCC_FULL = OCC_W'(DEPTH);

  logic [ENTRY_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]   wr_q, rd_q;
  logic [OCC_W-1:0]   occ_q;
  logic               ovf_q;
  logic               pop_ok, push_ok;

  assign pop_ok  = pop_i && (occ_q != '0);
  assign push_ok = push_i && ((occ_q != OCC_FULL) || pop_ok);

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      occ_q <= '0;
      ovf_q <= 1'b0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      occ_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (push_ok) wr_q <= ptr_next(wr_q);
      if (pop_ok)  rd_q <= ptr_next(rd_q);
      if (push_ok && !pop_ok)      occ_q <= occ_q + OCC_W'(1);
      else if (pop_ok && !push_ok) occ_q <= occ_q - OCC_W'(1);
      if (push_i && !push_ok) ovf_q <= 1'b1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  mem_q[g] <= '0;
      else if (!flush_i && push_ok && wr_q == PTR_W'(g)) mem_q[g] <= din_i;
    end
  end

  assign head_o  = mem_q[rd_q];
  assign avail_o = (occ_q != '0);
  assign ovf_o   = ovf_q;

  AST_OCC_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_q <= OCC_FULL); // R4
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !flush_i) |=> ovf_q); // R4
  AST_FLUSH_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (!avail_o && !ovf_q)); // R7
  AST_NO_SPURIOUS_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pop_i && !push_i && !flush_i) |=> $stable(occ_q)); // R6
endmodule

// File: rtl/hdlc_frame_status_fifo.sv
module hdlc_frame_status_fifo
  import hfs_pkg::*;
#(
  parameter int unsigned DEPTH_P = hfs_pkg::DEPTH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hdlc_mode_i,
  input  logic              fifo_en_i,
  input  logic              rx_wr_i,
  input  logic              flag_i,
  input  logic [STAT_W-1:0] eof_stat_i,
  input  logic              rd_lo_i,
  input  logic              rd_hi_i,
  output logic [7:0]        cnt_lo_o,
  output logic [7:0]        cnt_hi_o,
  output logic [STAT_W-1:0] stat_o,
  output logic              ovf_o,
  output logic              avail_o
);
  localparam int unsigned HI_W = CNT_W - 8;

  logic             active;
  logic [CNT_W-1:0] live_cnt;
  stat_entry_t      push_entry, head_entry;
  logic [CNT_W-1:0] view_cnt;
  logic             ovf, avail;

  assign active = hdlc_mode_i && fifo_en_i;

  hfs_byte_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (active),
    .inc_i     (rx_wr_i),
    .restart_i (flag_i),
    .cnt_o     (live_cnt)
  );

  assign push_entry.cnt  = live_cnt;
  assign push_entry.stat = frame_stat_t'(eof_stat_i);

  hfs_status_store #(.DEPTH(DEPTH_P), .ENTRY_W(ENTRY_W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (!fifo_en_i),
    .push_i  (flag_i && active),
    .pop_i   (rd_hi_i),
    .din_i   (push_entry),
    .head_o  (head_entry),
    .avail_o (avail),
    .ovf_o   (ovf)
  );

  assign view_cnt = avail ? head_entry.cnt : live_cnt;
  assign stat_o   = avail ? STAT_W'(head_entry.stat) : eof_stat_i;
  assign cnt_lo_o = view_cnt[7:0];
  assign cnt_hi_o = {ovf, avail, view_cnt[CNT_W-1 -: HI_W]};
  assign ovf_o    = ovf;
  assign avail_o  = avail;

  // rd_lo_i is a pure view strobe; it leaves the queue untouched.
  AST_LO_READ_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_lo_i && !rd_hi_i && !flag_i && fifo_en_i && avail) |=> avail); // R6
  AST_IDLE_MODE_NO_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hdlc_mode_i && fifo_en_i && !rd_hi_i && !avail) |=> !avail); // R10
endmodule

// File: tb/hdlc_frame_status_fifo_tb_top.sv
module hdlc_frame_status_fifo_tb_top;
  localparam int DEPTH = 10;
  localparam int CMAX  = 16383;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       hdlc_mode_i = 1'b0, fifo_en_i = 1'b0, rx_wr_i = 1'b0, flag_i = 1'b0;
  logic [4:0] eof_stat_i = '0;
  logic       rd_lo_i = 1'b0, rd_hi_i = 1'b0;
  logic [7:0] cnt_lo_o, cnt_hi_o;
  logic [4:0] stat_o;
  logic       ovf_o, avail_o;

  always #5 clk = ~clk;

  hdlc_frame_status_fifo dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .hdlc_mode_i(hdlc_mode_i), .fifo_en_i(fifo_en_i),
    .rx_wr_i(rx_wr_i), .flag_i(flag_i), .eof_stat_i(eof_stat_i), .rd_lo_i(rd_lo_i),
    .rd_hi_i(rd_hi_i), .cnt_lo_o(cnt_lo_o), .cnt_hi_o(cnt_hi_o), .stat_o(stat_o),
    .ovf_o(ovf_o), .avail_o(avail_o)
  );

  int n_chk = 0, n_bad = 0, cycles = 0;
  string cur_req = "R9";
  bit done = 1'b0;

  // model
  logic [18:0] m_q [DEPTH];
  int          m_occ = 0;
  int          m_cnt = 0;
  bit          m_ovf = 1'b0;

  function automatic logic [13:0] exp_view_cnt();
    return (m_occ > 0) ? m_q[0][13:0] : 14'(m_cnt);
  endfunction
  function automatic logic [7:0] exp_hi();
    logic [13:0] c = exp_view_cnt();
    return {m_ovf, (m_occ > 0), c[13:8]};
  endfunction
  function automatic logic [4:0] exp_stat();
    return (m_occ > 0) ? m_q[0][18:14] : eof_stat_i;
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check(cur_req, "cnt_lo_o", 32'(cnt_lo_o), 32'(exp_view_cnt() & 14'hFF));
    check(cur_req, "cnt_hi_o", 32'(cnt_hi_o), 32'(exp_hi()));
    check(cur_req, "stat_o",   32'(stat_o),   32'(exp_stat()));
    check(cur_req, "ovf_o",    32'(ovf_o),    32'(m_ovf));
    check(cur_req, "avail_o",  32'(avail_o),  32'(m_occ > 0));
  endtask

  // advance model over one edge using the currently driven inputs
  task automatic model_step();
    bit act   = hdlc_mode_i && fifo_en_i;
    bit pop   = rd_hi_i && (m_occ > 0);
    bit push  = flag_i && act;
    logic [18:0] ent = {eof_stat_i, 14'(m_cnt)};
    if (!fifo_en_i) begin
      m_occ = 0; m_ovf = 1'b0;
    end else begin
      if (pop) begin
        for (int i = 0; i < DEPTH - 1; i++) m_q[i] = m_q[i+1];
        m_occ--;
      end
      if (push) begin
        if (m_occ < DEPTH) begin m_q[m_occ] = ent; m_occ++; end
        else m_ovf = 1'b1;
      end
    end
    if (!act)        m_cnt = 0;
    else if (flag_i) m_cnt = rx_wr_i ? 1 : 0;
    else if (rx_wr_i && m_cnt < CMAX) m_cnt++;
  endtask

  task automatic tick();
    model_step();
    @(negedge clk);
    cycles++;
    compare_all();
  endtask

  task automatic idle_inputs();
    rx_wr_i = 0; flag_i = 0; rd_lo_i = 0; rd_hi_i = 0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) m_q[i] = '0;
    repeat (3) @(negedge clk);
    cur_req = "R9";
    compare_all();
    rst_ni = 1'b1;
    hdlc_mode_i = 1; fifo_en_i = 1;
    tick();

    // R1/R2: count five bytes, close frame with status
    cur_req = "R1";
    rx_wr_i = 1;
    repeat (5) tick();
    check("R1", "live count", 32'(cnt_lo_o), 32'd5);
    cur_req = "R2";
    flag_i = 1; rx_wr_i = 1; eof_stat_i = 5'b10101;
    tick();
    idle_inputs(); eof_stat_i = 5'b00011;
    check("R2", "head count", 32'(cnt_lo_o), 32'd5);
    check("R11", "head stat", 32'(stat_o), 32'h15);
    // R6: low read keeps entry
    cur_req = "R6";
    rd_lo_i = 1; tick(); rd_lo_i = 0;
    check("R6", "avail after lo read", 32'(avail_o), 32'd1);
    rd_hi_i = 1; tick(); rd_hi_i = 0;
    check("R6", "avail after hi read", 32'(avail_o), 32'd0);
    check("R2", "live restart at 1", 32'(cnt_lo_o), 32'd1);

    // R3: saturation
    cur_req = "R3";
    rx_wr_i = 1;
    repeat (CMAX + 8) tick();
    check("R3", "sat lo", 32'(cnt_lo_o), 32'hFF);
    check("R3", "sat hi", 32'(cnt_hi_o), 32'h3F);
    flag_i = 1; rx_wr_i = 0; eof_stat_i = 5'b01000;
    tick(); idle_inputs();
    check("R3", "stored sat hi", 32'(cnt_hi_o), 32'h7F);

    // R4/R8: fill past depth
    cur_req = "R4";
    for (int f = 0; f < DEPTH + 2; f++) begin
      rx_wr_i = 1; repeat (f + 1) tick();
      rx_wr_i = 0; flag_i = 1; eof_stat_i = 5'(f); tick(); flag_i = 0;
    end
    check("R4", "overflow bit", 32'(cnt_hi_o[7]), 32'd1);
    cur_req = "R8";
    check("R8", "first head is oldest", 32'(cnt_hi_o[5:0]), 32'h3F);
    rd_hi_i = 1; tick(); rd_hi_i = 0;
    check("R8", "second head", 32'(cnt_lo_o), 32'd1);
    check("R4", "ovf sticky after pop", 32'(ovf_o), 32'd1);

    // R10: mode low keeps entries, no push
    cur_req = "R10";
    hdlc_mode_i = 0; flag_i = 1; rx_wr_i = 1; tick(); idle_inputs();
    check("R10", "head kept", 32'(cnt_lo_o), 32'd1);
    rd_hi_i = 1; tick(); rd_hi_i = 0;
    check("R10", "read in idle mode", 32'(cnt_lo_o), 32'd2);
    hdlc_mode_i = 1;

    // R7: disable flushes
    cur_req = "R7";
    fifo_en_i = 0; tick();
    check("R7", "flushed avail", 32'(avail_o), 32'd0);
    check("R7", "ovf cleared", 32'(ovf_o), 32'd0);
    eof_stat_i = 5'b11011; tick();
    check("R7", "live status view", 32'(stat_o), 32'h1B);
    fifo_en_i = 1; tick();

    // random mix
    cur_req = "R5";
    for (int k = 0; k < 6000; k++) begin
      hdlc_mode_i = ($urandom_range(99) < 97);
      fifo_en_i   = ($urandom_range(199) != 0);
      rx_wr_i     = ($urandom_range(1) == 1);
      flag_i      = ($urandom_range(99) < 9);
      rd_hi_i     = ($urandom_range(99) < 6);
      rd_lo_i     = ($urandom_range(99) < 10);
      eof_stat_i  = 5'($urandom);
      tick();
    end
    idle_inputs();
    tick();
    done = 1'b1;
    summary();
  end
endmodule